// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable behavioural model of a parallel NOR flash device that speaks the common two-cycle command protocol. A host drives a simple synchronous bus with one address, a write strobe with write data, and a read strobe. The flash array is a small register file. Every bus write is treated as a command byte, or as an argument of a command already in progress, by a write-phase state machine. The command held in the machine picks what a read returns: array words, the 8-bit status register, identifier codes or bytes of the self-description query table.

The supported operations are single-word program, sector erase, buffered program, lock and unlock, status clear, status read, identifier read and query mode. A read-only input guards the array. While it is high, program and erase leave the array unchanged and set error flags in status. Program and erase take effect at once, so the ready flag is set as soon as the operation is accepted. The address is a byte address, and the array is organised in words of `DATA_W` bits. Command bytes are taken from bits 7:0 of the write data.

Top module: `nor_flash_cmd`

## Requirements
- R1: While reset is held, `rdData` is 0. After reset every array word reads as all ones, status is 0x00 and reads return array data.
- R2: A command byte of 0x00 or 0xFF written in the idle phase returns the device to array read mode.
- R3: A command of 0x10 or 0x40 arms a program. The next write stores its data at word `addr >> log2(DATA_W/8)`, sets status bit 7 (ready) and returns the device to array read mode.
- R4: Command 0x20 fills every word of the sector holding `addr` (sector = addr / SECTOR_BYTES) with all ones, leaves other sectors untouched and sets status bit 7. Until the device leaves this command, reads return the status register in bits 7:0, with the upper bits zero.
- R5: After an erase command, a following write of 0xD0 completes it and keeps status reads. A write of 0xFF, or of any other value, returns the device to array read mode.
- R6: While `roIn` is high, a program (single or buffered) sets status bit 4 (0x10), an erase sets status bit 5 (0x20), and the array is not modified. Status bits 6, 3, 2, 1 and 0 are always zero.
- R7: Command 0xE8 sets status bit 7. The next write gives a count N, the following N+1 writes each store one word, and a final 0xD0 closes the sequence. Reads return status throughout the sequence, and words past the N+1 written ones are not touched.
- R8: Command 0x50 clears the status register to 0x00 and returns the device to array read mode. Command 0x70 makes reads return the status register.
- R9: After command 0x90, a read computes the index `addr[7:0] >> log2(DATA_W/8)`. Index 0 returns MFR_CODE, index 1 returns DEV_CODE, and every other index returns 0.
- R10: After command 0x98, reads return query-table byte `index`, using the same index as R9. Bytes 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59, and an index of 49 or above returns 0. Writes other than 0xFF keep query mode, and 0xFF leaves it.
- R11: Command 0x60 followed by 0xD0 or 0x01 completes, sets status bit 7 and keeps status reads. Any other second byte returns the device to array read mode.
- R12: Any unlisted command byte written in the idle phase returns the device to array read mode.
- R13: `rdData` is registered. It presents the result one clock after `rdEn`, and it holds its value in every cycle without `rdEn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrEn | input | 1 | Write strobe; wrData is a command or argument |
| wrData | input | DATA_W | Write data; command byte in bits 7:0 |
| rdEn | input | 1 | Read strobe |
| roIn | input | 1 | Read-only guard for the array |
| rdData | output | DATA_W | Registered read data |

## Verification
The bound checker watches the internal strobes on every cycle. It confirms that the read-only guard blocks every array write, that an erase strobe appears only on a write carrying the erase byte, that a program is always followed by a set ready flag, that the unused status bits stay zero, and that read data holds while no read is issued. How multi-write sequences behave cannot be seen from strobes alone, so the bench's scenarios must show it: the erase confirm and its abort paths, the count and confirm phases of a buffered write, lock completion, and the index arithmetic of identifier and query reads. A behavioural model in the bench follows every cycle so that any divergence between scenarios is also caught.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  localparam logic [7:0] CMD_NOP     = 8'h00;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_PROG_A  = 8'h10;
  localparam logic [7:0] CMD_PROG_B  = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_LOCK    = 8'h60;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_BUFFER  = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_LOCKALT = 8'h01;

  localparam int ST_READY    = 7;
  localparam int ST_ERASEERR = 5;
  localparam int ST_PROGERR  = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARG,
    PH_BUFDATA,
    PH_BUFCONFIRM
  } phase_e;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STATUS,
    SRC_IDENT,
    SRC_QUERY
  } rdSrc_e;

  typedef struct packed {
    logic       progEn;
    logic       eraseEn;
    rdSrc_e     rdSrc;
    logic [7:0] statusVal;
  } ctrlStrobe_t;

endpackage

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_flash_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              roIn,
  output ctrlStrobe_t       strobe
);

  phase_e            phase, phaseNext;
  logic [7:0]        cmdReg, cmdNext;
  logic [7:0]        status, statusNext;
  logic [DATA_W-1:0] count, countNext;
  logic              progEn, eraseEn;
  logic [7:0]        cmdByte;
  rdSrc_e            rdSrc;

  assign cmdByte = wrData[7:0];

  always_comb begin
    phaseNext  = phase;
    cmdNext    = cmdReg;
    statusNext = status;
    countNext  = count;
    progEn     = 1'b0;
    eraseEn    = 1'b0;
    if (wrEn) begin
      unique case (phase)
        PH_IDLE: begin
          case (cmdByte)
            CMD_PROG_A, CMD_PROG_B, CMD_LOCK, CMD_QUERY: begin
              phaseNext = PH_ARG;
              cmdNext   = cmdByte;
            end
            CMD_ERASE: begin
              if (roIn) statusNext[ST_ERASEERR] = 1'b1;
              else      eraseEn = 1'b1;
              statusNext[ST_READY] = 1'b1;
              phaseNext = PH_ARG;
              cmdNext   = cmdByte;
            end
            CMD_BUFFER: begin
              statusNext[ST_READY] = 1'b1;
              phaseNext = PH_ARG;
              cmdNext   = cmdByte;
            end
            CMD_CLEAR: begin
              statusNext = 8'h00;
              phaseNext  = PH_IDLE;
              cmdNext    = CMD_NOP;
            end
            CMD_STATUS, CMD_IDENT: begin
              cmdNext = cmdByte;
            end
            default: begin
              phaseNext = PH_IDLE;
              cmdNext   = CMD_NOP;
            end
          endcase
        end
        PH_ARG: begin
          case (cmdReg)
            CMD_PROG_A, CMD_PROG_B: begin
              if (roIn) statusNext[ST_PROGERR] = 1'b1;
              else      progEn = 1'b1;
              statusNext[ST_READY] = 1'b1;
              phaseNext = PH_IDLE;
              cmdNext   = CMD_NOP;
            end
            CMD_ERASE: begin
              phaseNext = PH_IDLE;
              if (cmdByte == CMD_CONFIRM) statusNext[ST_READY] = 1'b1;
              else                        cmdNext = CMD_NOP;
            end
            CMD_LOCK: begin
              phaseNext = PH_IDLE;
              if (cmdByte == CMD_CONFIRM || cmdByte == CMD_LOCKALT)
                statusNext[ST_READY] = 1'b1;
              else
                cmdNext = CMD_NOP;
            end
            CMD_BUFFER: begin
              countNext = wrData;
              phaseNext = PH_BUFDATA;
            end
            CMD_QUERY: begin
              if (cmdByte == CMD_ARRAY) begin
                phaseNext = PH_IDLE;
                cmdNext   = CMD_NOP;
              end
            end
            default: begin
              phaseNext = PH_IDLE;
              cmdNext   = CMD_NOP;
            end
          endcase
        end
        PH_BUFDATA: begin
          if (roIn) statusNext[ST_PROGERR] = 1'b1;
          else      progEn = 1'b1;
          statusNext[ST_READY] = 1'b1;
          if (count == '0) phaseNext = PH_BUFCONFIRM;
          countNext = count - 1'b1;
        end
        PH_BUFCONFIRM: begin
          phaseNext = PH_IDLE;
          if (cmdByte == CMD_CONFIRM) statusNext[ST_READY] = 1'b1;
          else                        cmdNext = CMD_NOP;
        end
        default: begin
          phaseNext = PH_IDLE;
          cmdNext   = CMD_NOP;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cmdReg <= CMD_NOP;
      status <= 8'h00;
      count  <= '0;
    end else begin
      phase  <= phaseNext;
      cmdReg <= cmdNext;
      status <= statusNext;
      count  <= countNext;
    end
  end

  always_comb begin
    case (cmdReg)
      CMD_ERASE, CMD_CLEAR, CMD_LOCK, CMD_STATUS, CMD_BUFFER: rdSrc = SRC_STATUS;
      CMD_IDENT: rdSrc = SRC_IDENT;
      CMD_QUERY: rdSrc = SRC_QUERY;
      default:   rdSrc = SRC_ARRAY;
    endcase
  end

  assign strobe.progEn    = progEn;
  assign strobe.eraseEn   = eraseEn;
  assign strobe.rdSrc     = rdSrc;
  assign strobe.statusVal = status;

endmodule

// File: rtl/nor_flash_dp.sv
module nor_flash_dp
  import nor_flash_pkg::*;
#(
  parameter int              DATA_W       = 16,
  parameter int              ADDR_W       = 7,
  parameter int              SECTOR_BYTES = 16,
  parameter logic [15:0]     MFR_CODE     = 16'h0089,
  parameter logic [15:0]     DEV_CODE     = 16'h0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int BYTES       = DATA_W / 8;
  localparam int BYTE_SHIFT  = $clog2(BYTES);
  localparam int WORDS       = (2 ** ADDR_W) / BYTES;
  localparam int WIDX_W      = ADDR_W - BYTE_SHIFT;
  localparam int SECT_SHIFT  = $clog2(SECTOR_BYTES);
  localparam int SECT_WSHIFT = SECT_SHIFT - BYTE_SHIFT;
  localparam int SECT_W      = ADDR_W - SECT_SHIFT;
  localparam int BLOCKS      = (2 ** ADDR_W) / SECTOR_BYTES;
  localparam int QRY_LEN     = 49;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WIDX_W-1:0] wordIdx;
  logic [SECT_W-1:0] sectIdx;
  logic [7:0]        lowByte;
  logic [7:0]        tblIdx;

  assign wordIdx = addr[ADDR_W-1:BYTE_SHIFT];
  assign sectIdx = addr[ADDR_W-1:SECT_SHIFT];

  generate
    if (ADDR_W >= 8) begin : g_lowWide
      assign lowByte = addr[7:0];
    end else begin : g_lowNarrow
      assign lowByte = {{(8 - ADDR_W){1'b0}}, addr};
    end
  endgenerate

  assign tblIdx = lowByte >> BYTE_SHIFT;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [WIDX_W-1:0] MY_IDX  = WIDX_W'(w);
      localparam logic [SECT_W-1:0] MY_SECT = SECT_W'(w >> SECT_WSHIFT);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mem[w] <= '1;
        end else if (strobe.progEn && wordIdx == MY_IDX) begin
          mem[w] <= wrData;
        end else if (strobe.eraseEn && sectIdx == MY_SECT) begin
          mem[w] <= '1;
        end
      end
    end
  endgenerate

  function automatic logic [7:0] queryByte(input logic [7:0] idx);
    logic [7:0] val;
    case (idx)
      8'h10:   val = 8'h51;
      8'h11:   val = 8'h52;
      8'h12:   val = 8'h59;
      8'h13:   val = 8'h01;
      8'h27:   val = 8'(ADDR_W);
      8'h2C:   val = 8'h01;
      8'h2D:   val = 8'(BLOCKS - 1);
      8'h2E:   val = 8'((BLOCKS - 1) >> 8);
      8'h2F:   val = 8'(SECTOR_BYTES >> 8);
      8'h30:   val = 8'(SECTOR_BYTES >> 16);
      default: val = 8'h00;
    endcase
    if (idx >= 8'(QRY_LEN)) val = 8'h00;
    return val;
  endfunction

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    unique case (strobe.rdSrc)
      SRC_ARRAY:  rdNext = mem[wordIdx];
      SRC_STATUS: rdNext = DATA_W'(strobe.statusVal);
      SRC_IDENT: begin
        if (tblIdx == 8'd0)      rdNext = DATA_W'(MFR_CODE);
        else if (tblIdx == 8'd1) rdNext = DATA_W'(DEV_CODE);
        else                     rdNext = '0;
      end
      SRC_QUERY:  rdNext = DATA_W'(queryByte(tblIdx));
      default:    rdNext = mem[wordIdx];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
  import nor_flash_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          ADDR_W       = 7,
  parameter int          SECTOR_BYTES = 16,
  parameter logic [15:0] MFR_CODE     = 16'h0089,
  parameter logic [15:0] DEV_CODE     = 16'h0018
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              roIn,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobe_t ctrlStrobe;

  nor_flash_ctrl #(.DATA_W(DATA_W)) ctrlInst (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .roIn   (roIn),
    .strobe (ctrlStrobe)
  );

  nor_flash_dp #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .SECTOR_BYTES (SECTOR_BYTES),
    .MFR_CODE     (MFR_CODE),
    .DEV_CODE     (DEV_CODE)
  ) dpInst (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrData (wrData),
    .rdEn   (rdEn),
    .strobe (ctrlStrobe),
    .rdData (rdData)
  );

endmodule

// File: rtl/nor_flash_cmd_chk.sv
module nor_flash_cmd_chk
  import nor_flash_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic              roIn,
  input logic [DATA_W-1:0] rdData,
  input ctrlStrobe_t       strobe
);

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R6
  ro_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    roIn |-> !(strobe.progEn || strobe.eraseEn));

  // R4
  erase_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eraseEn |-> (wrEn && ((wrData & DATA_W'(8'hFF)) == DATA_W'(8'h20))
                        && !strobe.progEn));

  // R3
  prog_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progEn |=> strobe.statusVal[ST_READY]);

  // R3
  prog_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progEn |-> wrEn);

  // R6
  status_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statusVal & 8'h4F) == 8'h00);

endmodule

bind nor_flash_cmd nor_flash_cmd_chk #(.DATA_W(DATA_W)) chkInst (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdEn   (rdEn),
  .roIn   (roIn),
  .rdData (rdData),
  .strobe (ctrlStrobe)
);

// File: tb/nor_flash_cmd_test.sv
module nor_flash_cmd_test;

  localparam logic [15:0] MFR = 16'h0089;
  localparam logic [15:0] DEV = 16'h0018;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        roIn = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nor_flash_cmd uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .roIn(roIn), .rdData(rdData)
  );

  // behavioural reference model
  int          mPhase = 0;
  int          mCmd = 0;
  int          mStatus = 0;
  int          mCount = 0;
  logic [15:0] mArr [64];
  logic [15:0] mRd = '0;

  function automatic int qryModel(int idx);
    case (idx)
      16: return 'h51;
      17: return 'h52;
      18: return 'h59;
      19: return 1;
      'h27: return 7;
      'h2C: return 1;
      'h2D: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] readModel(int a);
    int idx = (a & 'hFF) >> 1;
    if (mCmd == 'h20 || mCmd == 'h50 || mCmd == 'h60 || mCmd == 'h70 || mCmd == 'hE8)
      return 16'(mStatus);
    if (mCmd == 'h90) return (idx == 0) ? MFR : (idx == 1) ? DEV : 16'h0;
    if (mCmd == 'h98) return 16'(qryModel(idx));
    return mArr[a >> 1];
  endfunction

  task automatic storeModel(int a, logic [15:0] d);
    if (roIn) mStatus = mStatus | 'h10;
    else      mArr[a >> 1] = d;
    mStatus = mStatus | 'h80;
  endtask

  task automatic writeModel(int a, logic [15:0] d);
    int c = int'(d[7:0]);
    if (mPhase == 0) begin
      if (c == 'h10 || c == 'h40 || c == 'h60 || c == 'h98) begin
        mPhase = 1; mCmd = c;
      end else if (c == 'h20) begin
        if (roIn) mStatus = mStatus | 'h20;
        else for (int k = 0; k < 8; k++) mArr[((a >> 4) * 8) + k] = 16'hFFFF;
        mStatus = mStatus | 'h80; mPhase = 1; mCmd = c;
      end else if (c == 'hE8) begin
        mStatus = mStatus | 'h80; mPhase = 1; mCmd = c;
      end else if (c == 'h50) begin
        mStatus = 0; mCmd = 0;
      end else if (c == 'h70 || c == 'h90) begin
        mCmd = c;
      end else begin
        mCmd = 0;
      end
    end else if (mPhase == 1) begin
      if (mCmd == 'h10 || mCmd == 'h40) begin
        storeModel(a, d); mPhase = 0; mCmd = 0;
      end else if (mCmd == 'h20) begin
        mPhase = 0;
        if (c == 'hD0) mStatus = mStatus | 'h80; else mCmd = 0;
      end else if (mCmd == 'h60) begin
        mPhase = 0;
        if (c == 'hD0 || c == 1) mStatus = mStatus | 'h80; else mCmd = 0;
      end else if (mCmd == 'hE8) begin
        mCount = int'(d); mPhase = 2;
      end else if (mCmd == 'h98) begin
        if (c == 'hFF) begin mPhase = 0; mCmd = 0; end
      end
    end else if (mPhase == 2) begin
      storeModel(a, d);
      if (mCount == 0) mPhase = 3;
      mCount = mCount - 1;
    end else begin
      mPhase = 0;
      if (c == 'hD0) mStatus = mStatus | 'h80; else mCmd = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCmd = 0; mStatus = 0; mCount = 0; mRd = '0;
      for (int k = 0; k < 64; k++) mArr[k] = 16'hFFFF;
    end else begin
      if (rdEn) mRd = readModel(int'(addr));
      if (wrEn) writeModel(int'(addr), wrData);
    end
  end

  task automatic check(logic [15:0] act, logic [15:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) check(rdData, mRd, "R13 model compare");
  end

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(logic [6:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdData, exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdData, 16'h0000, "R1 reset value");
    rstN = 1'b1;
    rdChk(7'h00, 16'hFFFF, "R1 array erased");
    rdChk(7'h22, 16'hFFFF, "R1 array erased");

    // single program
    wr(7'h04, 16'h0040); wr(7'h04, 16'h1234);
    rdChk(7'h04, 16'h1234, "R3 program 0x40");
    wr(7'h06, 16'h0010); wr(7'h06, 16'hABCD);
    rdChk(7'h06, 16'hABCD, "R3 program 0x10");
    wr(7'h00, 16'h0070);
    rdChk(7'h00, 16'h0080, "R8 status read ready");
    wr(7'h00, 16'h00FF);
    rdChk(7'h04, 16'h1234, "R2 0xFF array read");
    wr(7'h00, 16'h0070); wr(7'h00, 16'h0000);
    rdChk(7'h06, 16'hABCD, "R2 0x00 array read");

    // erase
    wr(7'h10, 16'h0040); wr(7'h10, 16'h1111);
    wr(7'h1E, 16'h0040); wr(7'h1E, 16'h2222);
    wr(7'h20, 16'h0040); wr(7'h20, 16'h3333);
    wr(7'h12, 16'h0020);
    rdChk(7'h12, 16'h0080, "R4 status after erase");
    wr(7'h00, 16'h00D0);
    rdChk(7'h00, 16'h0080, "R5 confirm keeps status");
    wr(7'h00, 16'h00FF);
    rdChk(7'h10, 16'hFFFF, "R4 sector start erased");
    rdChk(7'h1E, 16'hFFFF, "R4 sector end erased");
    rdChk(7'h20, 16'h3333, "R4 next sector kept");
    wr(7'h40, 16'h0040); wr(7'h40, 16'h4444);
    wr(7'h42, 16'h0020); wr(7'h42, 16'h00FF);
    rdChk(7'h40, 16'hFFFF, "R5 erase then 0xFF");
    wr(7'h50, 16'h0040); wr(7'h50, 16'h5555);
    wr(7'h52, 16'h0020); wr(7'h52, 16'h0033);
    rdChk(7'h50, 16'hFFFF, "R5 erase then bad byte");

    // status clear
    wr(7'h00, 16'h0050);
    rdChk(7'h04, 16'h1234, "R8 clear returns array");
    wr(7'h00, 16'h0070);
    rdChk(7'h00, 16'h0000, "R8 status cleared");

    // read-only guard
    roIn = 1'b1;
    wr(7'h20, 16'h0040); wr(7'h20, 16'h5555);
    wr(7'h00, 16'h0070);
    rdChk(7'h00, 16'h0090, "R6 program error");
    wr(7'h20, 16'h0020);
    rdChk(7'h00, 16'h00B0, "R6 erase error");
    wr(7'h00, 16'h00D0); wr(7'h00, 16'h00FF);
    rdChk(7'h20, 16'h3333, "R6 array unchanged");
    roIn = 1'b0;
    wr(7'h00, 16'h0050);

    // buffered program
    wr(7'h30, 16'h00E8);
    rdChk(7'h00, 16'h0080, "R7 buffer ready");
    wr(7'h30, 16'h0002);
    wr(7'h30, 16'hA1A1); wr(7'h32, 16'hA2A2); wr(7'h34, 16'hA3A3);
    rdChk(7'h00, 16'h0080, "R7 status before confirm");
    wr(7'h00, 16'h00D0);
    rdChk(7'h00, 16'h0080, "R7 status after confirm");
    wr(7'h00, 16'h00FF);
    rdChk(7'h30, 16'hA1A1, "R7 word 0");
    rdChk(7'h32, 16'hA2A2, "R7 word 1");
    rdChk(7'h34, 16'hA3A3, "R7 word 2");
    rdChk(7'h36, 16'hFFFF, "R7 word past count");

    // identifier
    wr(7'h00, 16'h0090);
    rdChk(7'h00, MFR, "R9 manufacturer");
    rdChk(7'h02, DEV, "R9 device");
    rdChk(7'h04, 16'h0000, "R9 other index");
    rdChk(7'h01, MFR, "R9 byte shift");
    wr(7'h00, 16'h00FF);

    // query
    wr(7'h00, 16'h0098);
    rdChk(7'h20, 16'h0051, "R10 query Q");
    rdChk(7'h22, 16'h0052, "R10 query R");
    rdChk(7'h24, 16'h0059, "R10 query Y");
    rdChk(7'h7E, 16'h0000, "R10 past length");
    wr(7'h00, 16'h0012);
    rdChk(7'h20, 16'h0051, "R10 stays in query");
    wr(7'h00, 16'h00FF);
    rdChk(7'h04, 16'h1234, "R10 exit query");

    // lock / unlock
    wr(7'h00, 16'h0060); wr(7'h00, 16'h0001);
    rdChk(7'h00, 16'h0080, "R11 lock 0x01");
    wr(7'h00, 16'h00FF);
    wr(7'h00, 16'h0060); wr(7'h00, 16'h00D0);
    rdChk(7'h00, 16'h0080, "R11 lock 0xD0");
    wr(7'h00, 16'h0060); wr(7'h00, 16'h0077);
    rdChk(7'h04, 16'h1234, "R11 lock bad byte");

    // unknown commands
    wr(7'h00, 16'h0070); wr(7'h00, 16'h0033);
    rdChk(7'h04, 16'h1234, "R12 unknown after status");
    wr(7'h00, 16'h00AB);
    rdChk(7'h06, 16'hABCD, "R12 unknown byte");

    // hold without read strobe
    @(negedge clk); addr = 7'h04;
    repeat (3) @(negedge clk);
    check(rdData, 16'hABCD, "R13 hold without rdEn");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule